// File: doc/BRIEF.md
# Staged Power-Good Sequencer

This block turns the verdict of a hot-plug supply path into three active-low power-good lines that fall in a fixed order. The first line latches low once two comparator results are true together: the output voltage has dropped below its drain threshold, and the pass transistor's gate is fully enhanced. It stays low until one of four fault sources releases it.

Once the first line is low, a cycle counter measures a programmable sequence delay. The second line falls when the delay has elapsed and the stage enable is high, whichever of the two happens later. The third line falls one further delay after the second, as long as the enable stays high. Dropping the enable, or releasing the first line, frees both later stages and restarts their timing.

All state is held in flip-flops that take a synchronous active-high reset. Every output is decoded from that registered state alone.

Top module: `pgood_sequencer`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `pgood1N`, `pgood2N` and `pgood3N` are 1 and `seqBusy` is 0.
- R2: `pgood1N` goes to 0 on the clock edge that samples `drainLow` and `gateHigh` both at 1, if no release source is active. Either input on its own leaves `pgood1N` at 1.
- R3: Any one of `clearReq`, `uvFault`, `lockoutFault` or `cbTimeout` sampled at 1 drives `pgood1N` to 1 on that edge. A release source wins over a simultaneous set condition.
- R4: Once `pgood1N` is 0, it stays 0 when `drainLow` and `gateHigh` fall back to 0.
- R5: With `seqEnable` held at 1 and a delay D ≥ 1 on `seqDelay`, `pgood2N` falls exactly D clock edges after the edge where `pgood1N` fell. A D of 0 behaves as 1.
- R6: If `seqEnable` is 0 when the first-stage delay expires, `pgood2N` falls on the first later edge that samples `seqEnable` at 1.
- R7: `pgood3N` falls exactly D edges after the edge where `pgood2N` fell, while `seqEnable` stays 1. A D of 0 behaves as 1.
- R8: Sampling `seqEnable` at 0 drives `pgood2N` and `pgood3N` to 1 on that edge and leaves `pgood1N` unchanged. When `seqEnable` returns to 1, `pgood2N` falls on the next edge, because the first-stage delay has already been served. `pgood3N` then needs a fresh full delay.
- R9: Releasing `pgood1N` drives `pgood2N` and `pgood3N` to 1 on the same edge and discards any partly counted delay. After the line latches again, `pgood2N` needs a full D edges.
- R10: `seqBusy` is 1 exactly while a stage delay is being counted. It is 1 from the edge that latches `pgood1N` until the edge that latches `pgood3N`, or until the first-stage delay expires if `seqEnable` is 0. It is 0 once `pgood3N` is low.
- R11: `clearReq` stops the sequence timer. `seqBusy` reads 0 after the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| drainLow | input | 1 | Output-voltage-below-threshold comparator result |
| gateHigh | input | 1 | Gate-fully-enhanced comparator result |
| clearReq | input | 1 | Global clear request |
| uvFault | input | 1 | Undervoltage condition |
| lockoutFault | input | 1 | Supply lockout condition |
| cbTimeout | input | 1 | Circuit-breaker fault time-out |
| seqEnable | input | 1 | Enable for stages two and three |
| seqDelay | input | DLY_W | Sequence delay in clock cycles |
| pgood1N | output | 1 | Stage-one power good, active low |
| pgood2N | output | 1 | Stage-two power good, active low |
| pgood3N | output | 1 | Stage-three power good, active low |
| seqBusy | output | 1 | Sequence timer is counting |

## Verification
Some properties are checked on every cycle by the assertions:
- the stage ordering: stage three low only when stage two is low, and stage two low only when stage one is low;
- the immediate release by any fault source, and its priority over the set condition;
- the latch hold and the latch set;
- the release of the later stages when the enable drops;
- the counter's step-by-one and its zeroing on restart.

The exact edge on which stages two and three fall can only be shown by the bench's directed scenarios. The same goes for the late-enable case, the re-enable that skips the first-stage delay, the discarded partial delay after a release, the zero-delay case, and the shape of `seqBusy` across a whole sequence.

// File: rtl/pgseq_pkg.sv
package pgseq_pkg;
  // Strobes from the stage control to the sequence counter
  typedef struct packed {
    logic run;      // count this cycle
    logic restart;  // discard any partial count
  } tmrCtl_t;
endpackage

// File: rtl/pgseq_timer.sv
module pgseq_timer
  import pgseq_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  tmrCtl_t          ctl,
  input  logic [DLY_W-1:0] seqDelay,
  output logic             expire
);
  localparam int CMP_W = DLY_W + 1;
  typedef logic [DLY_W-1:0] cnt_t;

  cnt_t             cnt;
  logic [CMP_W-1:0] nextElapsed;

  // Number of cycles served once this cycle is counted
  assign nextElapsed = {1'b0, cnt} + CMP_W'(1);
  assign expire      = ctl.run && (nextElapsed >= {1'b0, seqDelay});

  always_ff @(posedge clk) begin
    if (rst || ctl.restart) begin
      cnt <= '0;
    end else if (ctl.run) begin
      if (expire) cnt <= '0;
      else        cnt <= cnt + cnt_t'(1);
    end
  end

  p_restart_zero_r11: assert property (@(posedge clk) disable iff (rst)
    ctl.restart |=> (cnt == '0));

  p_count_step_r5: assert property (@(posedge clk) disable iff (rst)
    (ctl.run && !ctl.restart && !expire) |=> (cnt == cnt_t'($past(cnt) + cnt_t'(1))));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!ctl.run && !ctl.restart) |=> $stable(cnt));
endmodule

// File: rtl/pgseq_ctrl.sv
module pgseq_ctrl
  import pgseq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    drainLow,
  input  logic    gateHigh,
  input  logic    clearReq,
  input  logic    uvFault,
  input  logic    lockoutFault,
  input  logic    cbTimeout,
  input  logic    seqEnable,
  input  logic    expire,
  output tmrCtl_t ctl,
  output logic    pgood1N,
  output logic    pgood2N,
  output logic    pgood3N,
  output logic    seqBusy
);
  logic stage1, stage2, stage3;   // stage latched (power good active)
  logic dly1Done, dly2Done;       // delay after stage one / two served
  logic stage1Nxt, stage2Nxt, stage3Nxt, dly1Nxt, dly2Nxt;
  logic killAll, setCond, phase1, phase2;

  assign killAll = clearReq | uvFault | lockoutFault | cbTimeout;
  assign setCond = drainLow & gateHigh;
  assign phase1  = stage1 & ~dly1Done;
  assign phase2  = stage2 & ~dly2Done;

  assign ctl.run     = ~killAll & (phase1 | (phase2 & seqEnable));
  assign ctl.restart = killAll | (stage2 & ~seqEnable);

  always_comb begin
    stage1Nxt = ~killAll & (stage1 | setCond);
    dly1Nxt   = stage1Nxt & (dly1Done | (phase1 & expire));
    stage2Nxt = stage1Nxt & seqEnable & (stage2 | dly1Done | (phase1 & expire));
    dly2Nxt   = stage2Nxt & (dly2Done | (phase2 & expire));
    stage3Nxt = stage2Nxt & (stage3 | (phase2 & expire));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1   <= 1'b0;
      stage2   <= 1'b0;
      stage3   <= 1'b0;
      dly1Done <= 1'b0;
      dly2Done <= 1'b0;
    end else begin
      stage1   <= stage1Nxt;
      stage2   <= stage2Nxt;
      stage3   <= stage3Nxt;
      dly1Done <= dly1Nxt;
      dly2Done <= dly2Nxt;
    end
  end

  assign pgood1N = ~stage1;
  assign pgood2N = ~stage2;
  assign pgood3N = ~stage3;
  assign seqBusy = phase1 | phase2;

  p_fault_release_r3: assert property (@(posedge clk) disable iff (rst)
    killAll |=> pgood1N);

  p_latch_set_r2: assert property (@(posedge clk) disable iff (rst)
    (setCond && !killAll) |=> !pgood1N);

  p_latch_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!pgood1N && !killAll) |=> !pgood1N);

  p_enable_drop_r8: assert property (@(posedge clk) disable iff (rst)
    !seqEnable |=> (pgood2N && pgood3N));

  p_order_two_r9: assert property (@(posedge clk) disable iff (rst)
    !pgood2N |-> !pgood1N);

  p_order_three_r7: assert property (@(posedge clk) disable iff (rst)
    !pgood3N |-> !pgood2N);

  p_idle_when_done_r10: assert property (@(posedge clk) disable iff (rst)
    !pgood3N |-> !seqBusy);
endmodule

// File: rtl/pgood_sequencer.sv
module pgood_sequencer
  import pgseq_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             drainLow,
  input  logic             gateHigh,
  input  logic             clearReq,
  input  logic             uvFault,
  input  logic             lockoutFault,
  input  logic             cbTimeout,
  input  logic             seqEnable,
  input  logic [DLY_W-1:0] seqDelay,
  output logic             pgood1N,
  output logic             pgood2N,
  output logic             pgood3N,
  output logic             seqBusy
);
  tmrCtl_t tmrCtl;
  logic    tmrExpire;

  pgseq_ctrl i_ctrl (
    .clk          (clk),
    .rst          (rst),
    .drainLow     (drainLow),
    .gateHigh     (gateHigh),
    .clearReq     (clearReq),
    .uvFault      (uvFault),
    .lockoutFault (lockoutFault),
    .cbTimeout    (cbTimeout),
    .seqEnable    (seqEnable),
    .expire       (tmrExpire),
    .ctl          (tmrCtl),
    .pgood1N      (pgood1N),
    .pgood2N      (pgood2N),
    .pgood3N      (pgood3N),
    .seqBusy      (seqBusy)
  );

  pgseq_timer #(.DLY_W(DLY_W)) i_timer (
    .clk      (clk),
    .rst      (rst),
    .ctl      (tmrCtl),
    .seqDelay (seqDelay),
    .expire   (tmrExpire)
  );
endmodule

// File: tb/test_pgood_sequencer.sv
module test_pgood_sequencer;
  localparam int DLY_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             drainLow = 1'b0, gateHigh = 1'b0, clearReq = 1'b0;
  logic             uvFault = 1'b0, lockoutFault = 1'b0, cbTimeout = 1'b0;
  logic             seqEnable = 1'b0;
  logic [DLY_W-1:0] seqDelay = '0;
  logic             pgood1N, pgood2N, pgood3N, seqBusy;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  pgood_sequencer #(.DLY_W(DLY_W)) i_pgood_sequencer (
    .clk(clk), .rst(rst), .drainLow(drainLow), .gateHigh(gateHigh),
    .clearReq(clearReq), .uvFault(uvFault), .lockoutFault(lockoutFault),
    .cbTimeout(cbTimeout), .seqEnable(seqEnable), .seqDelay(seqDelay),
    .pgood1N(pgood1N), .pgood2N(pgood2N), .pgood3N(pgood3N), .seqBusy(seqBusy)
  );

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clearAll();
    drainLow = 1'b0; gateHigh = 1'b0; clearReq = 1'b1;
    step();
    clearReq = 1'b0;
  endtask

  task automatic latchStage1();
    drainLow = 1'b1; gateHigh = 1'b1;
    step();
    drainLow = 1'b0; gateHigh = 1'b0;
  endtask

  task automatic t_reset();
    step(2);
    chk("R1 pgood1N in reset", pgood1N, 1'b1);
    chk("R1 pgood2N in reset", pgood2N, 1'b1);
    chk("R1 pgood3N in reset", pgood3N, 1'b1);
    chk("R1 seqBusy in reset", seqBusy, 1'b0);
    rst = 1'b0;
    step();
    chk("R1 pgood1N after reset", pgood1N, 1'b1);
    chk("R1 seqBusy after reset", seqBusy, 1'b0);
  endtask

  task automatic t_latch();
    seqEnable = 1'b1; seqDelay = 8'd5;
    drainLow = 1'b1; step();
    chk("R2 drainLow alone", pgood1N, 1'b1);
    drainLow = 1'b0; gateHigh = 1'b1; step();
    chk("R2 gateHigh alone", pgood1N, 1'b1);
    drainLow = 1'b1; step();
    chk("R2 both true", pgood1N, 1'b0);
    drainLow = 1'b0; gateHigh = 1'b0; step();
    chk("R4 hold after inputs drop", pgood1N, 1'b0);
    clearAll();
  endtask

  task automatic t_chain();
    seqEnable = 1'b1; seqDelay = 8'd3;
    latchStage1();
    chk("R2 stage one low", pgood1N, 1'b0);
    chk("R10 busy during delay one", seqBusy, 1'b1);
    step(2);
    chk("R5 stage two before D", pgood2N, 1'b1);
    step();
    chk("R5 stage two at D", pgood2N, 1'b0);
    chk("R10 busy during delay two", seqBusy, 1'b1);
    step(2);
    chk("R7 stage three before D", pgood3N, 1'b1);
    step();
    chk("R7 stage three at D", pgood3N, 1'b0);
    chk("R10 idle when done", seqBusy, 1'b0);
  endtask

  task automatic t_enable_drop();
    seqEnable = 1'b0; step();
    chk("R8 stage two released", pgood2N, 1'b1);
    chk("R8 stage three released", pgood3N, 1'b1);
    chk("R8 stage one kept", pgood1N, 1'b0);
    seqEnable = 1'b1; step();
    chk("R8 stage two back at once", pgood2N, 1'b0);
    chk("R8 stage three waits", pgood3N, 1'b1);
    step(2);
    chk("R8 stage three before fresh D", pgood3N, 1'b1);
    step();
    chk("R8 stage three after fresh D", pgood3N, 1'b0);
    clearAll();
  endtask

  task automatic t_zero_delay();
    seqEnable = 1'b1; seqDelay = 8'd0;
    latchStage1();
    chk("R5 zero delay stage two waits", pgood2N, 1'b1);
    step();
    chk("R5 zero delay acts as one", pgood2N, 1'b0);
    step();
    chk("R7 zero delay acts as one", pgood3N, 1'b0);
    clearAll();
  endtask

  task automatic t_late_enable();
    seqEnable = 1'b0; seqDelay = 8'd2;
    latchStage1();
    step(4);
    chk("R6 stage two held without enable", pgood2N, 1'b1);
    chk("R10 idle after delay one without enable", seqBusy, 1'b0);
    seqEnable = 1'b1; step();
    chk("R6 stage two on enable", pgood2N, 1'b0);
    clearAll();
  endtask

  task automatic t_faults();
    seqEnable = 1'b1; seqDelay = 8'd2;
    for (int k = 0; k < 4; k++) begin
      latchStage1();
      step(2);
      chk("R3 setup stage two", pgood2N, 1'b0);
      clearReq = (k == 0); uvFault = (k == 1);
      lockoutFault = (k == 2); cbTimeout = (k == 3);
      step();
      chk("R3 fault releases stage one", pgood1N, 1'b1);
      chk("R9 stage two follows stage one", pgood2N, 1'b1);
      drainLow = 1'b1; gateHigh = 1'b1; step();
      chk("R3 fault beats set", pgood1N, 1'b1);
      drainLow = 1'b0; gateHigh = 1'b0;
      clearReq = 1'b0; uvFault = 1'b0; lockoutFault = 1'b0; cbTimeout = 1'b0;
    end
  endtask

  task automatic t_restart();
    seqEnable = 1'b1; seqDelay = 8'd4;
    latchStage1();
    step(2);
    clearReq = 1'b1; step(); clearReq = 1'b0;
    chk("R11 clear stops timer", seqBusy, 1'b0);
    latchStage1();
    step(3);
    chk("R9 partial count discarded", pgood2N, 1'b1);
    step();
    chk("R9 full delay after relatch", pgood2N, 1'b0);
    clearAll();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_latch();
    t_chain();
    t_enable_drop();
    t_zero_delay();
    t_late_enable();
    t_faults();
    t_restart();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule